// File: doc/BRIEF.md
# I2C/SMBus Control Register

This block holds the main control word of an I2C/SMBus peripheral. Software writes and reads it through a simple single-cycle register port. Bus events coming back from the protocol engine also change some of its bits: a sent start condition, a detected stop condition, a timeout, and a finished PEC byte. Every field is decoded and driven to the protocol engine on its own output.

Three bits are one-shot requests: start, stop and PEC. While any of them is pending, a software write may still change configuration bits and may withdraw requests. It cannot raise a request bit that is currently clear. Such a write also sets a sticky error flag. Hardware clears take priority over software writes that land in the same cycle.

Top module: `i2c_ctl_reg`

## Requirements
- R1: After reset the read value is 0x0000 and the write error flag is 0.
- R2: A write stores and reads back these fields at the bit positions given: peripheral enable bit 0, SMBus mode bit 1, SMBus host type bit 3, ARP enable bit 4, PEC enable bit 5, general-call enable bit 6, stretch disable bit 7, start request bit 8, stop request bit 9, acknowledge enable bit 10, PEC request bit 12. Each field also appears on its own output.
- R3: Bits 2, 11 and 13 to 15 always read 0, whatever value is written to them.
- R4: While bit 0 is 0, the acknowledge enable and start request bits are 0. This also holds when a single write clears bit 0 and sets either of those bits.
- R5: A start-sent pulse clears the start request bit in the following cycle.
- R6: A timeout pulse sets the stop request bit, and a stop-detected pulse clears it. When both arrive in the same cycle, the bit ends up cleared.
- R7: A PEC-done pulse clears the PEC request bit.
- R8: A write made while any of bits 8, 9 or 12 is set sets no request bit that was clear. It still updates the other fields and can clear request bits, and it sets the write error flag.
- R9: Once set, the write error flag stays set until reset.
- R10: When a hardware clear and a software write that sets the same bit occur in the same cycle, the bit ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Current register value |
| start_sent_i | input | 1 | Engine has sent a start condition |
| stop_seen_i | input | 1 | Stop condition detected on the bus |
| timeout_i | input | 1 | Bus timeout detected |
| pec_done_i | input | 1 | PEC byte transferred |
| en_o | output | 1 | Peripheral enable |
| smb_mode_o | output | 1 | SMBus mode select |
| smb_host_o | output | 1 | SMBus host type |
| arp_en_o | output | 1 | ARP enable |
| pec_en_o | output | 1 | PEC enable |
| gcall_en_o | output | 1 | General-call enable |
| stretch_off_o | output | 1 | Clock stretching disable |
| start_req_o | output | 1 | Start request pending |
| stop_req_o | output | 1 | Stop request pending |
| ack_en_o | output | 1 | Acknowledge enable |
| pec_req_o | output | 1 | PEC request pending |
| wr_err_o | output | 1 | Sticky flag: write attempted while a request was pending |

## Verification
The assertions run on every cycle and cover these invariants:
- Acknowledge enable and start request stay low whenever the enable bit is low.
- Each hardware event clears or sets its request bit one cycle later.
- A write made during a pending request never raises a clear request bit, and it flags the error.
- The error flag never falls.
- The reserved bits read zero.

Only the bench scenarios can show the rest:
- The complete field layout, seen by reading back specific write patterns.
- The outcome of two events that coincide, such as timeout together with stop detection, or a software set together with a hardware clear.
- That a rejected write still updates the configuration fields.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int unsigned REG_W      = 16;
  localparam int unsigned B_EN       = 0;
  localparam int unsigned B_SMB_MODE = 1;
  localparam int unsigned B_SMB_HOST = 3;
  localparam int unsigned B_ARP      = 4;
  localparam int unsigned B_PEC_EN   = 5;
  localparam int unsigned B_GCALL    = 6;
  localparam int unsigned B_STRETCH  = 7;
  localparam int unsigned B_START    = 8;
  localparam int unsigned B_STOP     = 9;
  localparam int unsigned B_ACK      = 10;
  localparam int unsigned B_PEC_REQ  = 12;
  localparam int unsigned N_REQ      = 3;
  localparam int unsigned N_CFG      = 7;

  // request slot order
  localparam int unsigned Q_START = 0;
  localparam int unsigned Q_STOP  = 1;
  localparam int unsigned Q_PEC   = 2;

  typedef struct packed {
    logic stretch_off;
    logic gcall_en;
    logic pec_en;
    logic arp_en;
    logic smb_host;
    logic smb_mode;
    logic en;
  } cfg_t;
endpackage

// File: rtl/i2c_ctl_guard.sv
module i2c_ctl_guard
  import i2c_ctl_pkg::*;
#(
  parameter int unsigned NREQ = N_REQ
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [NREQ-1:0] req_q_i,
  output logic            set_ok_o,
  output logic            err_o
);
  logic pending;
  logic err_q;

  assign pending  = |req_q_i;
  assign set_ok_o = !pending;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (wr_en_i && pending) err_q <= 1'b1;
  end

  assign err_o = err_q;
endmodule

// File: rtl/i2c_ctl_req_bit.sv
module i2c_ctl_req_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_val_i,
  input  logic set_ok_i,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  output logic q_o
);
  logic q, d;

  always_comb begin
    d = q;
    // a clear bit may only rise from software when no request is pending
    if (wr_en_i) d = wr_val_i & (q | set_ok_i);
    if (hw_set_i) d = 1'b1;
    if (hw_clr_i) d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/i2c_ctl_cfg.sv
module i2c_ctl_cfg
  import i2c_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  cfg_t cfg_w_i,
  input  logic ack_w_i,
  output cfg_t cfg_o,
  output logic ack_o,
  output logic en_next_o
);
  cfg_t cfg_q;
  logic ack_q, en_next;

  assign en_next = wr_en_i ? cfg_w_i.en : cfg_q.en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ack_q <= 1'b0;
    end else begin
      if (wr_en_i) cfg_q <= cfg_w_i;
      if (!en_next) ack_q <= 1'b0;
      else if (wr_en_i) ack_q <= ack_w_i;
    end
  end

  assign cfg_o     = cfg_q;
  assign ack_o     = ack_q;
  assign en_next_o = en_next;
endmodule

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_ctl_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          start_sent_i,
  input  logic          stop_seen_i,
  input  logic          timeout_i,
  input  logic          pec_done_i,
  output logic          en_o,
  output logic          smb_mode_o,
  output logic          smb_host_o,
  output logic          arp_en_o,
  output logic          pec_en_o,
  output logic          gcall_en_o,
  output logic          stretch_off_o,
  output logic          start_req_o,
  output logic          stop_req_o,
  output logic          ack_en_o,
  output logic          pec_req_o,
  output logic          wr_err_o
);
  localparam int unsigned REQ_POS [N_REQ] = '{B_START, B_STOP, B_PEC_REQ};

  cfg_t             cfg_w, cfg_q;
  logic             ack_q, en_next, set_ok;
  logic [N_REQ-1:0] req_q, hw_set, hw_clr;
  logic             unused_w;

  assign cfg_w.en          = wr_data_i[B_EN];
  assign cfg_w.smb_mode    = wr_data_i[B_SMB_MODE];
  assign cfg_w.smb_host    = wr_data_i[B_SMB_HOST];
  assign cfg_w.arp_en      = wr_data_i[B_ARP];
  assign cfg_w.pec_en      = wr_data_i[B_PEC_EN];
  assign cfg_w.gcall_en    = wr_data_i[B_GCALL];
  assign cfg_w.stretch_off = wr_data_i[B_STRETCH];
  assign unused_w = ^{wr_data_i[2], wr_data_i[11], wr_data_i[DW-1:13]};

  i2c_ctl_cfg cfg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .cfg_w_i   (cfg_w),
    .ack_w_i   (wr_data_i[B_ACK]),
    .cfg_o     (cfg_q),
    .ack_o     (ack_q),
    .en_next_o (en_next)
  );

  i2c_ctl_guard #(.NREQ(N_REQ)) guard_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .req_q_i  (req_q),
    .set_ok_o (set_ok),
    .err_o    (wr_err_o)
  );

  // hardware events per request slot; clear beats set
  assign hw_set[Q_START] = 1'b0;
  assign hw_clr[Q_START] = start_sent_i | !en_next;
  assign hw_set[Q_STOP]  = timeout_i;
  assign hw_clr[Q_STOP]  = stop_seen_i;
  assign hw_set[Q_PEC]   = 1'b0;
  assign hw_clr[Q_PEC]   = pec_done_i;

  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    i2c_ctl_req_bit req_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en_i),
      .wr_val_i (wr_data_i[REQ_POS[g]]),
      .set_ok_i (set_ok),
      .hw_set_i (hw_set[g]),
      .hw_clr_i (hw_clr[g]),
      .q_o      (req_q[g])
    );
  end

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[B_EN]       = cfg_q.en;
    rd_data_o[B_SMB_MODE] = cfg_q.smb_mode;
    rd_data_o[B_SMB_HOST] = cfg_q.smb_host;
    rd_data_o[B_ARP]      = cfg_q.arp_en;
    rd_data_o[B_PEC_EN]   = cfg_q.pec_en;
    rd_data_o[B_GCALL]    = cfg_q.gcall_en;
    rd_data_o[B_STRETCH]  = cfg_q.stretch_off;
    rd_data_o[B_ACK]      = ack_q;
    for (int i = 0; i < N_REQ; i++) rd_data_o[REQ_POS[i]] = req_q[i];
  end

  assign en_o          = cfg_q.en;
  assign smb_mode_o    = cfg_q.smb_mode;
  assign smb_host_o    = cfg_q.smb_host;
  assign arp_en_o      = cfg_q.arp_en;
  assign pec_en_o      = cfg_q.pec_en;
  assign gcall_en_o    = cfg_q.gcall_en;
  assign stretch_off_o = cfg_q.stretch_off;
  assign ack_en_o      = ack_q;
  assign start_req_o   = req_q[Q_START];
  assign stop_req_o    = req_q[Q_STOP];
  assign pec_req_o     = req_q[Q_PEC];
endmodule

// File: rtl/i2c_ctl_reg_chk.sv
module i2c_ctl_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic [15:0] wr_data_i,
  input logic [15:0] rd_data_o,
  input logic        start_sent_i,
  input logic        stop_seen_i,
  input logic        timeout_i,
  input logic        pec_done_i,
  input logic        en_o,
  input logic        start_req_o,
  input logic        stop_req_o,
  input logic        ack_en_o,
  input logic        pec_req_o,
  input logic        wr_err_o
);
  logic pend;
  assign pend = start_req_o | stop_req_o | pec_req_o;

  // R3
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[2] == 1'b0 && rd_data_o[11] == 1'b0 && rd_data_o[15:13] == 3'b000);

  // R4
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> (!ack_en_o && !start_req_o));

  // R5
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_sent_i |=> !start_req_o);

  // R6
  stop_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen_i |=> !stop_req_o);

  // R6
  timeout_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_i && !stop_seen_i) |=> stop_req_o);

  // R7
  pec_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pec_done_i |=> !pec_req_o);

  // R8
  blocked_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pend && !start_req_o) |=> !start_req_o);

  // R8
  blocked_pec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pend && !pec_req_o) |=> !pec_req_o);

  // R8
  err_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && pend) |=> wr_err_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |=> wr_err_o);

  logic unused_c;
  assign unused_c = ^wr_data_i;
endmodule

bind i2c_ctl_reg i2c_ctl_reg_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .start_sent_i (start_sent_i),
  .stop_seen_i  (stop_seen_i),
  .timeout_i    (timeout_i),
  .pec_done_i   (pec_done_i),
  .en_o         (en_o),
  .start_req_o  (start_req_o),
  .stop_req_o   (stop_req_o),
  .ack_en_o     (ack_en_o),
  .pec_req_o    (pec_req_o),
  .wr_err_o     (wr_err_o)
);

// File: tb/i2c_ctl_reg_tb.sv
module i2c_ctl_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        start_sent = 1'b0, stop_seen = 1'b0, timeout = 1'b0, pec_done = 1'b0;
  logic        en, smb_mode, smb_host, arp_en, pec_en, gcall_en, stretch_off;
  logic        start_req, stop_req, ack_en, pec_req, wr_err;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_ctl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .start_sent_i(start_sent), .stop_seen_i(stop_seen),
    .timeout_i(timeout), .pec_done_i(pec_done), .en_o(en), .smb_mode_o(smb_mode),
    .smb_host_o(smb_host), .arp_en_o(arp_en), .pec_en_o(pec_en),
    .gcall_en_o(gcall_en), .stretch_off_o(stretch_off), .start_req_o(start_req),
    .stop_req_o(stop_req), .ack_en_o(ack_en), .pec_req_o(pec_req), .wr_err_o(wr_err)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0; start_sent = 1'b0; stop_seen = 1'b0; timeout = 1'b0; pec_done = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one-cycle write; value registered at the posedge in between
  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 rd", rd_data, 16'h0000);
    chk("R1 err", {15'd0, wr_err}, 16'h0000);
  endtask

  task automatic t_layout();
    do_reset();
    wr(16'hECFF);
    chk("R2/R3 rd", rd_data, 16'h04FB);
    chk("R2 outs", {5'd0, ack_en, stop_req, start_req, stretch_off, gcall_en,
                    pec_en, arp_en, smb_host, 1'b0, smb_mode, en}, 16'h04FB);
    wr(16'h0022);
    chk("R2 rd2", rd_data, 16'h0022);
    chk("R3 rd2 outs", {15'd0, pec_en}, 16'h0001);
  endtask

  task automatic t_enable_clear();
    do_reset();
    wr(16'h0401);
    chk("R4 ack set", rd_data, 16'h0401);
    wr(16'h0400);
    chk("R4 ack cleared", rd_data, 16'h0000);
    wr(16'h0100);
    chk("R4 start blocked", rd_data, 16'h0000);
    chk("R4 no err", {15'd0, wr_err}, 16'h0000);
  endtask

  task automatic t_start_sent();
    do_reset();
    wr(16'h0101);
    chk("R5 start set", {15'd0, start_req}, 16'h0001);
    @(negedge clk); start_sent = 1'b1;
    @(negedge clk); start_sent = 1'b0;
    chk("R5 start cleared", rd_data, 16'h0001);
  endtask

  task automatic t_stop();
    do_reset();
    @(negedge clk); timeout = 1'b1;
    @(negedge clk); timeout = 1'b0;
    chk("R6 timeout sets stop", rd_data, 16'h0200);
    @(negedge clk); stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0;
    chk("R6 stop cleared", rd_data, 16'h0000);
    @(negedge clk); stop_seen = 1'b1; timeout = 1'b1;
    @(negedge clk); stop_seen = 1'b0; timeout = 1'b0;
    chk("R6 both same cycle", rd_data, 16'h0000);
  endtask

  task automatic t_pec();
    do_reset();
    wr(16'h1001);
    chk("R7 pec set", rd_data, 16'h1001);
    @(negedge clk); pec_done = 1'b1;
    @(negedge clk); pec_done = 1'b0;
    chk("R7 pec cleared", rd_data, 16'h0001);
  endtask

  task automatic t_guard();
    do_reset();
    wr(16'h0201);
    chk("R8 stop pending", rd_data, 16'h0201);
    wr(16'h1103);
    chk("R8 rejected sets", rd_data, 16'h0003);
    chk("R8 err", {15'd0, wr_err}, 16'h0001);
    wr(16'h0101);
    chk("R9 start after release", rd_data, 16'h0101);
    chk("R9 err sticky", {15'd0, wr_err}, 16'h0001);
  endtask

  task automatic t_race();
    do_reset();
    wr(16'h0001);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0101; start_sent = 1'b1;
    @(negedge clk); wr_en = 1'b0; start_sent = 1'b0;
    chk("R10 start clear wins", rd_data, 16'h0001);
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0201; stop_seen = 1'b1;
    @(negedge clk); wr_en = 1'b0; stop_seen = 1'b0;
    chk("R10 stop clear wins", rd_data, 16'h0001);
    chk("R10 no err", {15'd0, wr_err}, 16'h0000);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_layout();
        t_enable_clear();
        t_start_sent();
        t_stop();
        t_pec();
        t_guard();
        t_race();
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule